// File: doc/BRIEF.md
# Base-Delta Cache Line Decompressor

This block rebuilds a full 32-byte cache line from its compressed form. A compressed line is a 4-bit encoding code, a per-element base-select mask, one explicit base value of up to 8 bytes, and a payload that holds packed signed deltas. Each element of the output line is its delta, sign-extended to the element width, added either to the explicit base or to an implicit zero base. The mask chooses which, element by element. All elements are formed at the same time by one wide vector addition, and the result is registered. The block therefore has a fixed latency of one clock from input to output.

Six base/delta width pairings are supported, all with the same payload layout. Three further encodings cover an all-zero line, a line that repeats one 8-byte value, and a line that is stored uncompressed. Any other code raises an error flag and yields a zero line. A cache controller presents a compressed line with `in_valid` and takes the rebuilt line on the next cycle.

Top module: `bdi_line_decomp`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R2: While `rst_n` is low, `out_valid`, `out_err` and every bit of `out_line` are 0.
- R3: For a base/delta code, element e of width EW bytes occupies `out_line[e*8*EW +: 8*EW]`. Its delta of DW bytes is read from `payload[e*8*DW +: 8*DW]`. The element equals the sign-extended delta plus the base, taken modulo 2^(8*EW). The explicit base is the low EW bytes of `base_val`.
- R4: When `base_sel[e]` is 0, element e uses zero as its base, so the element is the sign-extended delta alone. When `base_sel[e]` is 1, it uses the explicit base.
- R5: The code values for the six pairings (base bytes / delta bytes) are: 2 = 8/1, 3 = 8/2, 4 = 8/4, 5 = 4/1, 6 = 4/2, 7 = 2/1. A line built from any pairing is rebuilt exactly.
- R6: Code 0 yields an all-zero line with `out_err` low.
- R7: Code 1 yields the 64-bit `base_val` copied into each of the four 8-byte slots of the line.
- R8: Code 15 passes `payload` through to `out_line` unchanged.
- R9: Codes 8 to 14 set `out_err` and yield an all-zero line.
- R10: Payload bits above the used deltas, `base_val` bits above the base width, and mask bits of absent elements have no effect on the result.
- R11: While `in_valid` is low, `out_line` and `out_err` keep the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A compressed line is present this cycle |
| enc_code | input | 4 | Encoding of the compressed line |
| base_sel | input | 16 | Per-element base choice: 1 = explicit base, 0 = zero |
| base_val | input | 64 | Explicit base, or the repeated value for code 1 |
| payload | input | 256 | Packed deltas from bit 0, or the raw line for code 15 |
| out_valid | output | 1 | The rebuilt line is valid |
| out_line | output | 256 | Rebuilt line, element 0 in the low bits |
| out_err | output | 1 | The last accepted code was not a known encoding |

## Verification
A wrong sign extension or a stuck mask bit corrupts only the elements it touches. Such a fault shows at `out_line` in the very cycle after the offending input, so the reference model compares the whole line on every clock. Lines are built in the bench from random bases, masks and deltas for each pairing. Unused payload, base and mask bits are filled with noise, so a slice taken from the wrong place is caught on the next output. Directed cases force wrap-around, negative deltas, all-immediate lines, every unknown code and idle cycles where the output must hold.

// File: rtl/bdi_decomp_pkg.sv
package bdi_decomp_pkg;

   typedef enum logic [3:0] {
      ENC_ZERO   = 4'd0,
      ENC_REPEAT = 4'd1,
      ENC_B8D1   = 4'd2,
      ENC_B8D2   = 4'd3,
      ENC_B8D4   = 4'd4,
      ENC_B4D1   = 4'd5,
      ENC_B4D2   = 4'd6,
      ENC_B2D1   = 4'd7,
      ENC_RAW    = 4'd15
   } enc_e;

   localparam int NUM_CFG      = 6;
   localparam int CODE_FIRST   = 2;
   localparam int WIDE_BASE_B  = 8;

   // base width in bytes for pairing k (code = CODE_FIRST + k)
   function automatic int cfg_base_bytes(input int k);
      case (k)
         0, 1, 2: return 8;
         3, 4:    return 4;
         default: return 2;
      endcase
   endfunction

   // delta width in bytes for pairing k
   function automatic int cfg_delta_bytes(input int k);
      case (k)
         0:       return 1;
         1:       return 2;
         2:       return 4;
         3:       return 1;
         4:       return 2;
         default: return 1;
      endcase
   endfunction

   function automatic logic [3:0] cfg_code(input int k);
      return 4'(CODE_FIRST + k);
   endfunction

endpackage

// File: rtl/bdi_width_unit.sv
// Rebuilds a line for one base/delta width pairing: every element is
// formed in parallel as (selected base) + (sign-extended delta).
module bdi_width_unit #(
   parameter int LINE_BYTES  = 32,
   parameter int BASE_BYTES  = 8,
   parameter int DELTA_BYTES = 1
) (
   input  logic [LINE_BYTES/BASE_BYTES-1:0]                   sel_mask,
   input  logic [8*BASE_BYTES-1:0]                            base_val,
   input  logic [(LINE_BYTES/BASE_BYTES)*8*DELTA_BYTES-1:0]   deltas,
   output logic [8*LINE_BYTES-1:0]                            line_out
);

   localparam int EW    = 8 * BASE_BYTES;
   localparam int DW    = 8 * DELTA_BYTES;
   localparam int NELEM = LINE_BYTES / BASE_BYTES;

   generate
      if (LINE_BYTES % BASE_BYTES != 0) begin : g_chk_div
         $error("bdi_width_unit: line size must be a multiple of the base size");
      end
      if (DELTA_BYTES >= BASE_BYTES) begin : g_chk_dw
         $error("bdi_width_unit: delta must be narrower than the base");
      end
   endgenerate

   generate
      for (genvar e = 0; e < NELEM; e++) begin : g_elem
         logic [DW-1:0] dlt;
         logic [EW-1:0] dlt_x;
         logic [EW-1:0] base_e;

         assign dlt    = deltas[e*DW +: DW];
         assign dlt_x  = {{(EW-DW){dlt[DW-1]}}, dlt};
         assign base_e = sel_mask[e] ? base_val : '0;
         assign line_out[e*EW +: EW] = base_e + dlt_x;
      end
   endgenerate

endmodule

// File: rtl/bdi_out_stage.sv
// Output register: captures the selected line on valid input and
// holds it otherwise.
module bdi_out_stage #(
   parameter int LINE_W = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [LINE_W-1:0] nxt_line,
   input  logic              nxt_err,
   output logic              out_valid,
   output logic [LINE_W-1:0] out_line,
   output logic              out_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_line  <= '0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_line <= nxt_line;
            out_err  <= nxt_err;
         end
      end
   end

   // R11: idle cycles leave the result untouched
   assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_line) && $stable(out_err)));

   // R1: valid follows input valid by exactly one cycle
   assert_valid_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

endmodule

// File: rtl/bdi_line_decomp.sv
module bdi_line_decomp
   import bdi_decomp_pkg::*;
#(
   parameter int LINE_BYTES = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [3:0]              enc_code,
   input  logic [LINE_BYTES/2-1:0] base_sel,
   input  logic [63:0]             base_val,
   input  logic [8*LINE_BYTES-1:0] payload,
   output logic                    out_valid,
   output logic [8*LINE_BYTES-1:0] out_line,
   output logic                    out_err
);

   localparam int LINE_W = 8 * LINE_BYTES;
   localparam int REP_N  = LINE_BYTES / WIDE_BASE_B;

   generate
      if (LINE_BYTES % WIDE_BASE_B != 0) begin : g_chk_line
         $error("bdi_line_decomp: line size must be a multiple of 8 bytes");
      end
   endgenerate

   logic [LINE_W-1:0] cand [NUM_CFG];

   generate
      for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
         localparam int BB = cfg_base_bytes(k);
         localparam int DB = cfg_delta_bytes(k);
         localparam int NE = LINE_BYTES / BB;

         bdi_width_unit #(
            .LINE_BYTES  (LINE_BYTES),
            .BASE_BYTES  (BB),
            .DELTA_BYTES (DB)
         ) u_unit (
            .sel_mask (base_sel[NE-1:0]),
            .base_val (base_val[8*BB-1:0]),
            .deltas   (payload[NE*8*DB-1:0]),
            .line_out (cand[k])
         );
      end
   endgenerate

   logic [LINE_W-1:0] sel_line;
   logic              sel_err;

   always_comb begin
      sel_line = '0;
      sel_err  = 1'b0;
      if (enc_code == ENC_ZERO) begin
         sel_line = '0;
      end else if (enc_code == ENC_REPEAT) begin
         sel_line = {REP_N{base_val}};
      end else if (enc_code == ENC_RAW) begin
         sel_line = payload;
      end else begin
         sel_err = 1'b1;
         for (int k = 0; k < NUM_CFG; k++) begin
            if (enc_code == cfg_code(k)) begin
               sel_line = cand[k];
               sel_err  = 1'b0;
            end
         end
      end
   end

   bdi_out_stage #(
      .LINE_W (LINE_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .nxt_line  (sel_line),
      .nxt_err   (sel_err),
      .out_valid (out_valid),
      .out_line  (out_line),
      .out_err   (out_err)
   );

   // R6: zero encoding
   assert_zero_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_code == ENC_ZERO) |=> (out_line == '0 && !out_err));

   // R7: repeated value fills every 8-byte slot
   assert_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_code == ENC_REPEAT) |=>
         (out_line == {REP_N{$past(base_val)}} && !out_err));

   // R8: raw line passes through
   assert_raw_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && enc_code == ENC_RAW) |=> (out_line == $past(payload) && !out_err));

   // R9: unknown code flags an error and gives zeros
   assert_unknown_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (enc_code inside {[4'd8:4'd14]})) |=> (out_err && out_line == '0));

   // R5: a known pairing code never raises the error flag
   assert_known_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (enc_code inside {[4'd2:4'd7]})) |=> !out_err);

endmodule

// File: tb/bdi_line_decomp_tb.sv
module bdi_line_decomp_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   enc_code = '0;
   logic [15:0]  base_sel = '0;
   logic [63:0]  base_val = '0;
   logic [255:0] payload = '0;
   logic         out_valid;
   logic [255:0] out_line;
   logic         out_err;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   bdi_line_decomp u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .enc_code  (enc_code),
      .base_sel  (base_sel),
      .base_val  (base_val),
      .payload   (payload),
      .out_valid (out_valid),
      .out_line  (out_line),
      .out_err   (out_err)
   );

   typedef struct {
      logic         v;
      logic [255:0] line;
      logic         err;
      string        tag;
   } exp_t;

   exp_t         expq[$];
   logic [255:0] held_line = '0;
   logic         held_err  = 1'b0;

   function automatic logic [255:0] rnd256();
      logic [255:0] r = '0;
      for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom();
      return r;
   endfunction

   task automatic compare_one();
      exp_t e;
      if (expq.size() == 0) return;
      e = expq.pop_front();
      checks++;
      if (out_valid !== e.v || out_line !== e.line || out_err !== e.err) begin
         fails++;
         $display("FAIL %s: actual v=%b err=%b line=%h expected v=%b err=%b line=%h",
                  e.tag, out_valid, out_err, out_line, e.v, e.err, e.line);
      end
   endtask

   // one clock: check the previous result, drive new input, queue expectation
   task automatic step(input logic v, input logic [3:0] c, input logic [15:0] m,
                       input logic [63:0] b, input logic [255:0] p,
                       input logic [255:0] el, input logic ee, input string tag);
      exp_t e;
      @(negedge clk);
      compare_one();
      in_valid = v; enc_code = c; base_sel = m; base_val = b; payload = p;
      if (v) begin held_line = el; held_err = ee; end
      e.v = v; e.line = held_line; e.err = held_err; e.tag = tag;
      expq.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(1'b0, $urandom(), $urandom(), {$urandom(), $urandom()}, rnd256(), '0, 1'b0, tag);
   endtask

   // builds a compressed line for one pairing and the line it must rebuild
   task automatic build(input int bb, input int db, input logic [63:0] base,
                        input logic [15:0] m, output logic [255:0] pay,
                        output logic [255:0] line);
      logic [63:0] emask, dmask, d, dx, el;
      int n;
      n     = 32 / bb;
      emask = (bb == 8) ? '1 : ((64'd1 << (8*bb)) - 64'd1);
      dmask = (64'd1 << (8*db)) - 64'd1;
      pay   = rnd256();          // noise above the used deltas (R10)
      for (int i = 0; i < n*8*db; i++) pay[i] = 1'b0;
      line  = '0;
      for (int e = 0; e < n; e++) begin
         d  = {$urandom(), $urandom()} & dmask;
         dx = d[8*db-1] ? (d | ~dmask) : d;
         el = ((m[e] ? base : 64'd0) + dx) & emask;
         pay  = pay  | (256'(d)  << (e*8*db));
         line = line | (256'(el) << (e*8*bb));
      end
   endtask

   function automatic int tb_bb(input int k);
      case (k) 0, 1, 2: return 8; 3, 4: return 4; default: return 2; endcase
   endfunction
   function automatic int tb_db(input int k);
      case (k) 0: return 1; 1: return 2; 2: return 4; 3: return 1; 4: return 2; default: return 1; endcase
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [255:0] pay, line, p;
      logic [63:0]  b;
      logic [15:0]  m;

      // R2: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_err !== 1'b0 || out_line !== '0) begin
         fails++;
         $display("FAIL R2: actual v=%b err=%b line=%h expected all zero",
                  out_valid, out_err, out_line);
      end
      rst_n = 1'b1;
      idle("R2");

      // R6: zero line, with noisy other inputs
      step(1'b1, 4'd0, 16'hFFFF, 64'hDEAD_BEEF_0123_4567, rnd256(), '0, 1'b0, "R6");
      // R7: repeated value
      b = 64'h0000_00FF_1234_ABCD;
      step(1'b1, 4'd1, 16'h0, b, rnd256(), {4{b}}, 1'b0, "R7");
      // R8: raw pass-through
      p = rnd256();
      step(1'b1, 4'd15, 16'h1234, 64'h0, p, p, 1'b0, "R8");
      // R11: hold across idle cycles
      idle("R11"); idle("R11"); idle("R1");

      // R3: wrap-around, base 0xFFFFFFFF plus delta 1 in 4/1 pairing gives 0
      p = '0;
      for (int e = 0; e < 8; e++) p[e*8 +: 8] = 8'h01;
      p[255:128] = '1;
      step(1'b1, 4'd5, 16'hFFFF, 64'hA5A5_A5A5_FFFF_FFFF, p, '0, 1'b0, "R3");
      // R3: negative delta 0x80 on base 0x100 in 8/1 pairing gives 0x80
      p = '0;
      for (int e = 0; e < 4; e++) p[e*8 +: 8] = 8'h80;
      step(1'b1, 4'd2, 16'h000F, 64'h100, p, {4{64'h80}}, 1'b0, "R3");
      // R4: all-immediate 2/1 pairing, deltas 0xFF give 0xFFFF elements
      p = '0;
      for (int e = 0; e < 16; e++) p[e*8 +: 8] = 8'hFF;
      step(1'b1, 4'd7, 16'h0000, 64'h7777_7777_7777_7777, p, '1, 1'b0, "R4");
      // R4: mixed mask on 8/2 pairing
      p = '0;
      p[15:0] = 16'h0005; p[31:16] = 16'hFFFE; p[47:32] = 16'h0001; p[63:48] = 16'h8000;
      line = {64'hFFFF_FFFF_FFFF_8000, 64'h1000_0000_0000_0001,
              64'hFFFF_FFFF_FFFF_FFFE, 64'h1000_0000_0000_0005};
      step(1'b1, 4'd3, 16'b1010_0000_0000_0101, 64'h1000_0000_0000_0000, p,
           line, 1'b0, "R4");

      // R9: every unknown code, then a good line clears the flag
      for (int c = 8; c <= 14; c++)
         step(1'b1, 4'(c), 16'hFFFF, 64'hFFFF_0000_FFFF_0000, rnd256(), '0, 1'b1, "R9");
      idle("R11");
      step(1'b1, 4'd0, 16'h0, 64'h0, '0, '0, 1'b0, "R9");

      // R5 / R10: random round trip through every pairing
      for (int k = 0; k < 6; k++) begin
         for (int t = 0; t < 40; t++) begin
            b = {$urandom(), $urandom()};
            m = 16'($urandom());
            build(tb_bb(k), tb_db(k), b & ((tb_bb(k) == 8) ? 64'hFFFF_FFFF_FFFF_FFFF
                                              : ((64'd1 << (8*tb_bb(k))) - 64'd1)),
                  m, pay, line);
            step(1'b1, 4'(2 + k), m, b, pay, line, 1'b0, (t % 2 == 0) ? "R5" : "R10");
            if (t % 7 == 3) idle("R11");
         end
      end

      idle("R1");
      @(negedge clk);
      compare_one();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule